// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block is a memory-mapped interval timer with three independent 32-bit counting channels behind a simple register bus. The bus has an address, write data, a write strobe, a read strobe and combinational read data. A shared clock-control register holds an 8-bit divider and a suspend bit. The divider turns the core clock into a slower step pulse. Each channel selects either that pulse or the raw clock as its counting source.

Each channel has four registers:
- A configuration word that chooses the counting direction, one-shot or continuous operation, and the counting source.
- A write-only command register with start, halt and load bits.
- A 32-bit reload value.
- A live count that can be read at any time.

When a channel reaches its terminal value it flags an event in a shared status bank. An enable bank, which has separate set and clear registers, masks each channel's event onto a single interrupt line. A debug halt input freezes every channel, but only while the suspend bit is set.

Top module: `tri_chan_timer`

## Requirements
- R1: After reset every count reads 0, every reload reads 0xFFFF_FFFF, the clock-control register, the enable bank and the status bank read 0, and irq_o is low.
- R2: A running channel that counts down and has one-shot mode clear steps from its count to 0. On the step after 0 it reloads the reload value and sets its status bit in that same step. The period is therefore reload+1 steps.
- R3: In one-shot mode (configuration bit 3 = 1) a channel that reaches its terminal value sets its status bit on the next step. It then stops, and its count holds at that value.
- R4: With configuration bit 1 = 1 a channel counts up from 0. On the step after the count equals the reload value, it returns to 0 (continuous mode) and sets its status bit.
- R5: Command bit 2 (load) makes the channel take its load value on the next step and set no status bit. The load value is the reload value when counting down and 0 when counting up. Counting continues from the load value if the channel is running.
- R6: Command bit 0 starts a channel and command bit 1 stops it, so the count holds. When both bits are written together, stop wins.
- R7: With configuration bit 4 = 1 a channel steps once every D clocks, where D is the clock-control divider field (bits 15:8). A D of 0 or 1 steps every clock.
- R8: With configuration bit 4 = 0 a channel steps on every clock.
- R9: Channel N uses bit 2N in each interrupt register.
  - Writing 1 to bit 2N at 0xF4 sets the enable bit.
  - Writing 1 to bit 2N at 0xF0 clears the enable bit.
  - Writing 1 to bit 2N at 0xFC clears the status bit.
  - irq_o is the OR of the status bits whose enable bit is set.
  - A status bit can be set only by its channel's terminal event.
- R10: While the suspend bit (clock-control bit 4) and halt_i are both 1, no count changes. halt_i has no effect while suspend is 0.
- R11: Channels are independent. Activity on one channel leaves the others' counts unchanged.
- R12: The register map is as follows:
  - The clock-control register is at 0x00.
  - For channel X, the configuration, command, reload and count registers are at 0x10, 0x18, 0x20 and 0x28, each plus X*0x20.
  - Registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_i | input | 1 | Debug halt; freezes the counts when the suspend bit is set |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_rd | input | 1 | Read strobe; qualifies bus_rdata |
| bus_rdata | output | 32 | Combinational read data, 0 when bus_rd is low |
| irq_o | output | 1 | Interrupt, the OR of enabled pending status bits |

## Verification
The assertions assume that halt_i and the bus strobes are synchronous to clk and are never changed close to a rising edge. The divider check also tolerates a divider rewrite between two pulses, because software may reprogram the divider at any time. The stimulus changes every input only on a falling edge and issues at most one write per clock. For each timing check it counts the rising edges between the command write and the sample.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Address map (byte offsets); per-channel offsets advance by CH_STRIDE.
  localparam logic [7:0] CLK_CTL_OFF  = 8'h00;
  localparam logic [7:0] CH_CFG_BASE  = 8'h10;
  localparam logic [7:0] CH_CMD_BASE  = 8'h18;
  localparam logic [7:0] CH_RLD_BASE  = 8'h20;
  localparam logic [7:0] CH_CNT_BASE  = 8'h28;
  localparam logic [7:0] CH_STRIDE    = 8'h20;
  localparam logic [7:0] IEN_CLR_OFF  = 8'hF0;
  localparam logic [7:0] IEN_SET_OFF  = 8'hF4;
  localparam logic [7:0] IST_OFF      = 8'hFC;

  // Field positions
  localparam int SUSP_BIT    = 4;
  localparam int DIV_LSB     = 8;
  localparam int CFG_UP_BIT  = 1;
  localparam int CFG_OS_BIT  = 3;
  localparam int CFG_EXT_BIT = 4;
  localparam int CMD_GO_BIT  = 0;
  localparam int CMD_HLT_BIT = 1;
  localparam int CMD_LD_BIT  = 2;

  typedef struct packed {
    logic ext;      // count on the prescaled step pulse
    logic oneshot;  // stop after one terminal event
    logic up;       // count upward from 0 to reload
  } chan_cfg_t;

  function automatic logic [7:0] ch_addr(input logic [7:0] base, input int idx);
    return base + 8'(idx) * CH_STRIDE;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             freeze_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pc_q, pc_d;
  logic [DIV_W:0]   pc_inc;

  always_comb begin
    pc_inc = {1'b0, pc_q} + 1'b1;
    tick_o = !freeze_i && (pc_inc >= {1'b0, div_i});
    if (freeze_i)    pc_d = pc_q;
    else if (tick_o) pc_d = '0;
    else             pc_d = pc_inc[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R7: with a divider of 2 or more, two pulses never fall on adjacent clocks
  p_tick_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i >= 2) |=> (!tick_o || div_i != $past(div_i)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  chan_cfg_t        cfg_wdata,
  input  logic             cmd_wr,
  input  logic             cmd_go,
  input  logic             cmd_halt,
  input  logic             cmd_load,
  input  logic             rld_wr,
  input  logic [CNT_W-1:0] rld_wdata,
  input  logic             tick_i,
  input  logic             freeze_i,
  output chan_cfg_t        cfg_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  chan_cfg_t        cfg_q, cfg_d;
  logic [CNT_W-1:0] rld_q, rld_d, cnt_q, cnt_d;
  logic             run_q, run_d, pend_q, pend_d;
  logic             step, at_end;

  always_comb begin
    step     = !freeze_i && (cfg_q.ext ? tick_i : 1'b1);
    at_end   = cfg_q.up ? (cnt_q == rld_q) : (cnt_q == '0);
    expire_o = step && !pend_q && run_q && at_end;

    cfg_d = cfg_wr ? cfg_wdata : cfg_q;
    rld_d = rld_wr ? rld_wdata : rld_q;

    cnt_d = cnt_q;
    if (step && pend_q) begin
      cnt_d = cfg_q.up ? '0 : rld_q;
    end else if (step && run_q) begin
      if (at_end) begin
        if (!cfg_q.oneshot) cnt_d = cfg_q.up ? '0 : rld_q;
      end else begin
        cnt_d = cfg_q.up ? cnt_q + 1'b1 : cnt_q - 1'b1;
      end
    end

    run_d = run_q;
    if (cmd_wr) begin
      if (cmd_halt)    run_d = 1'b0;
      else if (cmd_go) run_d = 1'b1;
    end else if (expire_o && cfg_q.oneshot) begin
      run_d = 1'b0;
    end

    pend_d = pend_q;
    if (cmd_wr && cmd_load) pend_d = 1'b1;
    else if (step)          pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      rld_q  <= '1;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      rld_q  <= rld_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      pend_q <= pend_d;
    end
  end

  assign cfg_o    = cfg_q;
  assign reload_o = rld_q;
  assign count_o  = cnt_q;

  // R3: a one-shot terminal event leaves the channel stopped
  p_oneshot_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && cfg_q.oneshot && !cmd_wr) |=> !run_q);

  // R10: frozen cycles never move the count
  p_freeze_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> $stable(cnt_q));

  // R5: a pending down-count load restores the reload value on the step
  p_load_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pend_q && !cfg_q.up) |=> (cnt_q == $past(rld_q)));

  // R2: a continuous down-count terminal event wraps to the reload value
  p_down_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !cfg_q.oneshot && !cfg_q.up) |=> (cnt_q == $past(rld_q)));
endmodule

// File: rtl/tri_chan_timer.sv
module tri_chan_timer
  import tmr_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int CNT_W = 32,
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        halt_i,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        irq_o
);
  localparam int IRQ_SPAN = 2 * NCH;

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // Clock-control register
  logic             susp_q, susp_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             clk_ctl_wr, freeze, tick;

  assign clk_ctl_wr = bus_wr && (bus_addr == CLK_CTL_OFF);
  assign freeze     = susp_q && halt_i;

  always_comb begin
    susp_d = clk_ctl_wr ? bus_wdata[SUSP_BIT] : susp_q;
    div_d  = clk_ctl_wr ? bus_wdata[DIV_LSB +: DIV_W] : div_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      susp_q <= 1'b0;
      div_q  <= '0;
    end else begin
      susp_q <= susp_d;
      div_q  <= div_d;
    end
  end

  tmr_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .div_i    (div_q),
    .freeze_i (freeze),
    .tick_o   (tick)
  );

  // Channels
  chan_cfg_t        cfg_arr [NCH];
  logic [CNT_W-1:0] rld_arr [NCH];
  logic [CNT_W-1:0] cnt_arr [NCH];
  logic [NCH-1:0]   expire;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic      cfg_wr, cmd_wr, rld_wr;
    chan_cfg_t cfg_w;
    assign cfg_wr = bus_wr && (bus_addr == ch_addr(CH_CFG_BASE, i));
    assign cmd_wr = bus_wr && (bus_addr == ch_addr(CH_CMD_BASE, i));
    assign rld_wr = bus_wr && (bus_addr == ch_addr(CH_RLD_BASE, i));
    assign cfg_w  = '{ext:     bus_wdata[CFG_EXT_BIT],
                      oneshot: bus_wdata[CFG_OS_BIT],
                      up:      bus_wdata[CFG_UP_BIT]};

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_w),
      .cmd_wr    (cmd_wr),
      .cmd_go    (bus_wdata[CMD_GO_BIT]),
      .cmd_halt  (bus_wdata[CMD_HLT_BIT]),
      .cmd_load  (bus_wdata[CMD_LD_BIT]),
      .rld_wr    (rld_wr),
      .rld_wdata (bus_wdata[CNT_W-1:0]),
      .tick_i    (tick),
      .freeze_i  (freeze),
      .cfg_o     (cfg_arr[i]),
      .reload_o  (rld_arr[i]),
      .count_o   (cnt_arr[i]),
      .expire_o  (expire[i])
    );
  end

  // Interrupt banks: channel N at bit 2N
  logic [NCH-1:0] ien_q, ien_d, ist_q, ist_d;
  logic [NCH-1:0] ien_set, ien_clr, ist_clr;

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      ien_set[k] = bus_wr && (bus_addr == IEN_SET_OFF) && bus_wdata[2*k];
      ien_clr[k] = bus_wr && (bus_addr == IEN_CLR_OFF) && bus_wdata[2*k];
      ist_clr[k] = bus_wr && (bus_addr == IST_OFF)     && bus_wdata[2*k];
    end
    ien_d = (ien_q & ~ien_clr) | ien_set;
    ist_d = (ist_q & ~ist_clr) | expire;   // a new event beats a clear
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ien_q <= '0;
      ist_q <= '0;
    end else begin
      ien_q <= ien_d;
      ist_q <= ist_d;
    end
  end

  assign irq_o = |(ist_q & ien_q);

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == CLK_CTL_OFF) begin
        bus_rdata[SUSP_BIT]            = susp_q;
        bus_rdata[DIV_LSB +: DIV_W]    = div_q;
      end
      if (bus_addr == IEN_SET_OFF)
        for (int k = 0; k < NCH; k++) bus_rdata[2*k] = ien_q[k];
      if (bus_addr == IST_OFF)
        for (int k = 0; k < NCH; k++) bus_rdata[2*k] = ist_q[k];
      for (int k = 0; k < NCH; k++) begin
        if (bus_addr == ch_addr(CH_CFG_BASE, k)) begin
          bus_rdata[CFG_UP_BIT]  = cfg_arr[k].up;
          bus_rdata[CFG_OS_BIT]  = cfg_arr[k].oneshot;
          bus_rdata[CFG_EXT_BIT] = cfg_arr[k].ext;
        end
        if (bus_addr == ch_addr(CH_RLD_BASE, k)) bus_rdata[CNT_W-1:0] = rld_arr[k];
        if (bus_addr == ch_addr(CH_CNT_BASE, k)) bus_rdata[CNT_W-1:0] = cnt_arr[k];
      end
    end
  end

  // R9: a status bit only rises on its own channel's terminal event
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_status_cause_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
      $rose(ist_q[i]) |-> $past(expire[i]));
  end

  // R9: the interrupt stays low while nothing enabled is pending
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ien_q == '0) |-> !irq_o);

  initial begin
    a_span_r9: assert (IRQ_SPAN <= 32);
  end
endmodule

// File: tb/tb_tri_chan_timer.sv
module tb_tri_chan_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        halt_i;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  tri_chan_timer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_i    (halt_i),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  function automatic logic [7:0] a_cfg(input int c); return 8'h10 + 8'(c) * 8'h20; endfunction
  function automatic logic [7:0] a_cmd(input int c); return 8'h18 + 8'(c) * 8'h20; endfunction
  function automatic logic [7:0] a_rld(input int c); return 8'h20 + 8'(c) * 8'h20; endfunction
  function automatic logic [7:0] a_cnt(input int c); return 8'h28 + 8'(c) * 8'h20; endfunction

  // All tasks are entered on a falling edge.
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    chk_reg("R1 count0", a_cnt(0), 32'h0);
    chk_reg("R1 reload2", a_rld(2), 32'hFFFF_FFFF);
    chk_reg("R1 clkctl", 8'h00, 32'h0);
    chk_reg("R1 ien", 8'hF4, 32'h0);
    chk_reg("R1 status", 8'hFC, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_down_cont();
    bus_write(a_cfg(0), 32'h0);
    bus_write(a_rld(0), 32'd3);
    chk_reg("R12 reload0 readback", a_rld(0), 32'd3);
    bus_write(8'hF4, 32'h1);
    bus_write(a_cmd(0), 32'h5);          // go + load
    edges(1); chk_reg("R5 R8 load step", a_cnt(0), 32'd3);
    edges(3); chk_reg("R2 reached zero", a_cnt(0), 32'd0);
    chk_reg("R2 no event at zero", 8'hFC, 32'h0);
    edges(1); chk_reg("R2 wrap to reload", a_cnt(0), 32'd3);
    chk_reg("R2 R9 status bit0", 8'hFC, 32'h1);
    chk("R9 irq raised", {31'h0, irq_o}, 32'h1);
    bus_write(8'hFC, 32'h1);
    chk_reg("R9 status cleared", 8'hFC, 32'h0);
    chk("R9 irq dropped", {31'h0, irq_o}, 32'h0);
    bus_write(a_cmd(0), 32'h2);          // stop: this edge still steps 2->1
    edges(3); chk_reg("R6 stopped holds", a_cnt(0), 32'd1);
    bus_write(a_cmd(0), 32'h3);          // go + stop: stop wins
    edges(2); chk_reg("R6 stop beats go", a_cnt(0), 32'd1);
  endtask

  task automatic t_oneshot();
    bus_write(a_cfg(1), 32'h8);
    chk_reg("R12 cfg1 readback", a_cfg(1), 32'h8);
    bus_write(a_rld(1), 32'd2);
    bus_write(8'hF4, 32'h4);
    chk_reg("R9 enable set", 8'hF4, 32'h5);
    bus_write(a_cmd(1), 32'h5);
    edges(3); chk_reg("R3 at zero", a_cnt(1), 32'd0);
    chk_reg("R3 no event yet", 8'hFC, 32'h0);
    edges(1); chk_reg("R3 status bit2", 8'hFC, 32'h4);
    chk_reg("R3 count held", a_cnt(1), 32'd0);
    edges(3); chk_reg("R3 stays stopped", a_cnt(1), 32'd0);
    chk_reg("R11 channel0 untouched", a_cnt(0), 32'd1);
    chk("R9 irq ch1", {31'h0, irq_o}, 32'h1);
    bus_write(8'hF0, 32'h4);
    chk_reg("R9 enable cleared", 8'hF4, 32'h1);
    chk("R9 masked irq", {31'h0, irq_o}, 32'h0);
    chk_reg("R9 status kept", 8'hFC, 32'h4);
    bus_write(8'hFC, 32'h4);
    chk_reg("R9 status2 cleared", 8'hFC, 32'h0);
  endtask

  task automatic t_up();
    bus_write(a_cfg(2), 32'h2);
    bus_write(a_rld(2), 32'd2);
    bus_write(a_cmd(2), 32'h5);
    edges(2); chk_reg("R4 up 1", a_cnt(2), 32'd1);
    edges(1); chk_reg("R4 up 2", a_cnt(2), 32'd2);
    chk_reg("R4 no event yet", 8'hFC, 32'h0);
    edges(1); chk_reg("R4 wrap to 0", a_cnt(2), 32'd0);
    chk_reg("R4 status bit4", 8'hFC, 32'h10);
    bus_write(a_cmd(2), 32'h2);
    bus_write(8'hFC, 32'h10);
  endtask

  task automatic t_reload_cmd();
    bus_write(a_rld(0), 32'd10);
    bus_write(a_cmd(0), 32'h5);
    edges(1); chk_reg("R5 start", a_cnt(0), 32'd10);
    edges(3); chk_reg("R5 counting", a_cnt(0), 32'd7);
    bus_write(a_cmd(0), 32'h4);          // load only, still running
    chk_reg("R5 step before load", a_cnt(0), 32'd6);
    edges(1); chk_reg("R5 restarted", a_cnt(0), 32'd10);
    chk_reg("R5 no status", 8'hFC, 32'h0);
    edges(1); chk_reg("R5 continues", a_cnt(0), 32'd9);
    bus_write(a_cmd(0), 32'h2);
  endtask

  task automatic t_prescale();
    int i100 = -1, i99 = -1, i98 = -1;
    logic [31:0] v;
    bus_write(8'h00, 32'h0000_0400);
    chk_reg("R12 clkctl readback", 8'h00, 32'h0000_0400);
    bus_write(a_cfg(1), 32'h10);
    bus_write(a_rld(1), 32'd100);
    bus_write(a_cmd(1), 32'h5);
    for (int i = 0; i < 30; i++) begin
      bus_read(a_cnt(1), v);
      if (v == 100 && i100 < 0) i100 = i;
      if (v == 99  && i99  < 0) i99  = i;
      if (v == 98  && i98  < 0) i98  = i;
      edges(1);
    end
    chk("R7 first gap", 32'(i99 - i100), 32'd4);
    chk("R7 second gap", 32'(i98 - i99), 32'd4);
  endtask

  task automatic t_freeze();
    logic [31:0] x, y;
    bus_write(8'h00, 32'h10);            // suspend, divider 0
    halt_i = 1'b1;
    bus_read(a_cnt(1), x);
    edges(5); chk_reg("R10 frozen", a_cnt(1), x);
    bus_write(8'h00, 32'h0);             // suspend off, halt still high
    bus_read(a_cnt(1), y);
    chk("R10 frozen through write", y, x);
    edges(3); chk_reg("R7 R10 halt ignored", a_cnt(1), y - 32'd3);
    halt_i = 1'b0;
    bus_write(a_cmd(1), 32'h2);
  endtask

  initial begin
    rst_n = 1'b0; halt_i = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_wr = 1'b0; bus_rd = 1'b0;
    edges(3);
    rst_n = 1'b1;
    edges(3);
    t_reset();
    t_down_cont();
    t_oneshot();
    t_up();
    t_reload_cmd();
    t_prescale();
    t_freeze();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule